// File: doc/BRIEF.md
# Receive Buffer Space Tracker

This block follows the fill level of the receive buffer that is currently in use. A packet arrives as a stream of beats, with a start marker on the first beat and an end marker on the last. The block gives a memory write address for every beat it accepts. Packets are placed back to back in one contiguous region, and a packet is never split between two buffers. One cycle after the last beat of a packet, the block outputs a completion record. The record holds the packet's start address, its byte count, and a flag that is set when this packet closed the buffer.

After every packet, the block compares the words still free against a programmable end-of-buffer threshold. If fewer words remain than the threshold, it releases the buffer and asks the resource descriptor fetcher for another one. Software loads the first buffer while the receiver is disabled and enables reception afterwards.

If the fetcher has no descriptor to give, the block raises a resource-exhausted status. Every packet that arrives while no buffer is held is dropped whole. A new buffer load clears the status. The beat width is a parameter: 2 bytes selects the 16-bit variant and 4 bytes selects the 32-bit variant. Word counts are always in 16-bit words.

Top module: `rxbuf_space_tracker`

## Requirements
- R1: A loaded buffer address is forced to beat alignment. Bit 0 is cleared when BEAT_BYTES=2, and bits 1:0 are cleared when BEAT_BYTES=4. The first packet then starts at that aligned address.
- R2: A packet is accepted only when its start beat arrives while rx_enable=1 and a buffer is held. Otherwise none of its beats assert wr_en, and pkt_drop pulses for one cycle after its end beat.
- R3: wr_en follows an accepted beat in the same cycle. Within a packet, wr_addr advances by BEAT_BYTES per accepted beat. Idle cycles between beats do not move it.
- R4: The next accepted packet starts at the address directly after the last beat of the previous packet in the same buffer.
- R5: One cycle after an accepted end beat, done_valid pulses and done_addr gives the packet start address. done_bytes gives the byte count: BEAT_BYTES for each earlier beat, plus pkt_last_bytes for the end beat, where a value of 0 means a full beat.
- R6: rem_words drops by BEAT_BYTES/2 words for every accepted beat and saturates at 0. The new value is visible the cycle after the beat.
- R7: After an accepted end beat, the buffer is released if the remaining words are below eob_words. done_last is 1 in that case and 0 when the remaining words are equal to or above the threshold. fetch_req is high whenever rx_enable=1 and no buffer is held.
- R8: fetch_empty=1 while fetch_req=1 sets rsrc_exhausted in the next cycle. The status holds until a buffer load, and packets arriving meanwhile are dropped.
- R9: A buffer load (buf_load_valid) clears rsrc_exhausted and drops fetch_req. rem_words then shows the loaded word count.
- R10: After reset, no buffer is held: wr_en, done_valid, pkt_drop, rsrc_exhausted and rem_words are 0. fetch_req is 0 while rx_enable=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receiver enable |
| eob_words | input | WC_W | End-of-buffer threshold in 16-bit words |
| buf_load_valid | input | 1 | Load a new buffer |
| buf_load_addr | input | ADDR_W | Byte address of the new buffer |
| buf_load_wc | input | WC_W | Size of the new buffer in 16-bit words |
| fetch_req | output | 1 | Request for a new buffer descriptor |
| fetch_empty | input | 1 | Fetcher has no descriptor available |
| rsrc_exhausted | output | 1 | No buffer could be obtained |
| pkt_valid | input | 1 | Beat present |
| pkt_sop | input | 1 | First beat of a packet |
| pkt_eop | input | 1 | Last beat of a packet |
| pkt_last_bytes | input | LB_W | Valid bytes in the end beat, 0 meaning full |
| wr_en | output | 1 | Beat accepted, write to memory |
| wr_addr | output | ADDR_W | Byte address for the beat |
| rem_words | output | WC_W | Words left in the current buffer |
| done_valid | output | 1 | Completion record valid |
| done_addr | output | ADDR_W | Packet start address |
| done_bytes | output | BCNT_W | Packet byte count |
| done_last | output | 1 | Packet closed the buffer |
| pkt_drop | output | 1 | A whole packet was discarded |

## Verification
The bench targets the threshold boundary. When exactly the threshold number of words remains, the buffer must be kept. A design that compared with less-or-equal would close it one packet early and raise done_last too soon. The bench sends a packet larger than the space left; a tracker without saturation would wrap rem_words to a huge value and never ask for a buffer. It loads unaligned addresses, so a missing mask shows up as an odd start address. It also drives idle gaps inside a packet and one-byte end beats, which expose pointers that move on idle cycles and byte counts that treat every beat as full. Finally, it sends packets while the receiver is disabled and while resources are exhausted, where a faulty design would write or report completion for traffic it should discard.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   typedef enum logic [1:0] {
      PK_IDLE = 2'd0,
      PK_KEEP = 2'd1,
      PK_DROP = 2'd2
   } pk_state_t;
endpackage

// File: rtl/rxb_buf_regs.sv
module rxb_buf_regs #(
   parameter int ADDR_W     = 32,
   parameter int WC_W       = 16,
   parameter int BEAT_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [WC_W-1:0]   load_wc,
   input  logic              beat_take,
   input  logic              beat_end,
   input  logic [WC_W-1:0]   eob_words,
   output logic [ADDR_W-1:0] ptr,
   output logic [WC_W-1:0]   wc,
   output logic              have_buf,
   output logic              low_space
);
   localparam int WPB = BEAT_BYTES / 2;

   logic [ADDR_W-1:0] aligned_addr;
   logic [WC_W-1:0]   wc_dec;

   generate
      if (BEAT_BYTES == 2) begin : g_align16
         assign aligned_addr = {load_addr[ADDR_W-1:1], 1'b0};
      end else begin : g_align32
         assign aligned_addr = {load_addr[ADDR_W-1:2], 2'b00};
      end
   endgenerate

   always_comb begin
      if (wc >= WC_W'(WPB)) wc_dec = wc - WC_W'(WPB);
      else                  wc_dec = '0;
   end

   assign low_space = (wc_dec < eob_words);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         wc       <= '0;
         have_buf <= 1'b0;
      end else if (load_valid) begin
         ptr      <= aligned_addr;
         wc       <= load_wc;
         have_buf <= 1'b1;
      end else if (beat_take) begin
         ptr <= ptr + ADDR_W'(BEAT_BYTES);
         wc  <= wc_dec;
         if (beat_end && low_space) have_buf <= 1'b0;
      end
   end
endmodule

// File: rtl/rxb_pkt_track.sv
module rxb_pkt_track
   import rxb_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BCNT_W     = 16,
   parameter int BEAT_BYTES = 2,
   parameter int LB_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic              pkt_sop,
   input  logic              pkt_eop,
   input  logic [LB_W-1:0]   pkt_last_bytes,
   input  logic              can_accept,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              low_space,
   output logic              take,
   output logic              done_valid,
   output logic [ADDR_W-1:0] done_addr,
   output logic [BCNT_W-1:0] done_bytes,
   output logic              done_last,
   output logic              pkt_drop
);
   pk_state_t         state;
   logic [BCNT_W-1:0] cnt;
   logic [ADDR_W-1:0] start_r;
   logic [BCNT_W-1:0] beat_bytes_now;
   logic [BCNT_W-1:0] total;
   logic [ADDR_W-1:0] start_now;
   logic              drop_end;

   assign take = pkt_valid && (pkt_sop ? can_accept : (state == PK_KEEP));

   always_comb begin
      if (pkt_eop && (pkt_last_bytes != '0)) beat_bytes_now = BCNT_W'(pkt_last_bytes);
      else                                   beat_bytes_now = BCNT_W'(BEAT_BYTES);
      total     = (pkt_sop ? '0 : cnt) + beat_bytes_now;
      start_now = pkt_sop ? ptr : start_r;
      drop_end  = pkt_valid && pkt_eop && !take && (pkt_sop || (state == PK_DROP));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= PK_IDLE;
         cnt        <= '0;
         start_r    <= '0;
         done_valid <= 1'b0;
         done_addr  <= '0;
         done_bytes <= '0;
         done_last  <= 1'b0;
         pkt_drop   <= 1'b0;
      end else begin
         done_valid <= take && pkt_eop;
         pkt_drop   <= drop_end;
         if (pkt_valid) begin
            if (pkt_eop)      state <= PK_IDLE;
            else if (pkt_sop) state <= can_accept ? PK_KEEP : PK_DROP;
         end
         if (take) begin
            cnt     <= total;
            start_r <= start_now;
         end
         if (take && pkt_eop) begin
            done_addr  <= start_now;
            done_bytes <= total;
            done_last  <= low_space;
         end
      end
   end
endmodule

// File: rtl/rxb_fetch_ctl.sv
module rxb_fetch_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_enable,
   input  logic have_buf,
   input  logic fetch_empty,
   input  logic load_valid,
   output logic fetch_req,
   output logic rsrc_exhausted
);
   assign fetch_req = rx_enable && !have_buf;

   always_ff @(posedge clk) begin
      if (!rst_n)                        rsrc_exhausted <= 1'b0;
      else if (load_valid)               rsrc_exhausted <= 1'b0;
      else if (fetch_req && fetch_empty) rsrc_exhausted <= 1'b1;
   end
endmodule

// File: rtl/rxbuf_space_tracker.sv
module rxbuf_space_tracker #(
   parameter int ADDR_W     = 32,
   parameter int WC_W       = 16,
   parameter int BCNT_W     = 16,
   parameter int BEAT_BYTES = 2,
   localparam int LB_W      = $clog2(BEAT_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_enable,
   input  logic [WC_W-1:0]   eob_words,
   input  logic              buf_load_valid,
   input  logic [ADDR_W-1:0] buf_load_addr,
   input  logic [WC_W-1:0]   buf_load_wc,
   output logic              fetch_req,
   input  logic              fetch_empty,
   output logic              rsrc_exhausted,
   input  logic              pkt_valid,
   input  logic              pkt_sop,
   input  logic              pkt_eop,
   input  logic [LB_W-1:0]   pkt_last_bytes,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WC_W-1:0]   rem_words,
   output logic              done_valid,
   output logic [ADDR_W-1:0] done_addr,
   output logic [BCNT_W-1:0] done_bytes,
   output logic              done_last,
   output logic              pkt_drop
);
   generate
      if (!(BEAT_BYTES == 2 || BEAT_BYTES == 4)) begin : g_bad_beat
         $error("BEAT_BYTES must be 2 or 4");
      end
      if (ADDR_W < 8 || WC_W < 2 || BCNT_W < 4) begin : g_bad_width
         $error("width parameter too small");
      end
   endgenerate

   logic [ADDR_W-1:0] ptr;
   logic              have_buf;
   logic              low_space;
   logic              take;

   rxb_buf_regs #(
      .ADDR_W(ADDR_W), .WC_W(WC_W), .BEAT_BYTES(BEAT_BYTES)
   ) buf_i (
      .clk(clk), .rst_n(rst_n),
      .load_valid(buf_load_valid), .load_addr(buf_load_addr), .load_wc(buf_load_wc),
      .beat_take(take), .beat_end(pkt_eop), .eob_words(eob_words),
      .ptr(ptr), .wc(rem_words), .have_buf(have_buf), .low_space(low_space)
   );

   rxb_pkt_track #(
      .ADDR_W(ADDR_W), .BCNT_W(BCNT_W), .BEAT_BYTES(BEAT_BYTES), .LB_W(LB_W)
   ) pkt_i (
      .clk(clk), .rst_n(rst_n),
      .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
      .pkt_last_bytes(pkt_last_bytes),
      .can_accept(rx_enable && have_buf), .ptr(ptr), .low_space(low_space),
      .take(take), .done_valid(done_valid), .done_addr(done_addr),
      .done_bytes(done_bytes), .done_last(done_last), .pkt_drop(pkt_drop)
   );

   rxb_fetch_ctl fetch_i (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .have_buf(have_buf),
      .fetch_empty(fetch_empty), .load_valid(buf_load_valid),
      .fetch_req(fetch_req), .rsrc_exhausted(rsrc_exhausted)
   );

   assign wr_en   = take;
   assign wr_addr = ptr;
endmodule

// File: rtl/rxbuf_space_tracker_chk.sv
module rxbuf_space_tracker_chk #(
   parameter int ADDR_W     = 32,
   parameter int BEAT_BYTES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_enable,
   input logic              buf_load_valid,
   input logic              fetch_req,
   input logic              rsrc_exhausted,
   input logic              pkt_valid,
   input logic              pkt_sop,
   input logic              pkt_eop,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              done_valid,
   input logic              pkt_drop
);
   localparam int AL = $clog2(BEAT_BYTES);

   logic [ADDR_W-1:0] exp_next;

   always_ff @(posedge clk) begin
      if (!rst_n)     exp_next <= '0;
      else if (wr_en) exp_next <= wr_addr + ADDR_W'(BEAT_BYTES);
   end

   // R1
   wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr[AL-1:0] == '0));

   // R3
   beat_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pkt_sop) |-> (wr_addr == exp_next));

   // R2
   disabled_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pkt_sop && !rx_enable) |-> !wr_en);

   // R8
   no_buf_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !(wr_en && pkt_sop));

   // R5
   done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(wr_en && pkt_eop));

   // R2
   drop_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_drop |-> $past(pkt_valid && pkt_eop && !wr_en));

   // R9
   load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(buf_load_valid) |-> !rsrc_exhausted);
endmodule

bind rxbuf_space_tracker rxbuf_space_tracker_chk #(
   .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)
) chk_i (.*);

// File: tb/rxbuf_space_tracker_tb_top.sv
module rxbuf_space_tracker_tb_top;
   localparam int ADDR_W = 32;
   localparam int WC_W   = 16;
   localparam int BCNT_W = 16;
   localparam int EOB    = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              rx_enable;
   logic [WC_W-1:0]   eob_words;
   logic              buf_load_valid;
   logic [ADDR_W-1:0] buf_load_addr;
   logic [WC_W-1:0]   buf_load_wc;
   logic              fetch_req;
   logic              fetch_empty;
   logic              rsrc_exhausted;
   logic              pkt_valid, pkt_sop, pkt_eop;
   logic [1:0]        pkt_last_bytes;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [WC_W-1:0]   rem_words;
   logic              done_valid;
   logic [ADDR_W-1:0] done_addr;
   logic [BCNT_W-1:0] done_bytes;
   logic              done_last;
   logic              pkt_drop;

   int total = 0;
   int bad   = 0;
   longint exp_ptr;
   longint exp_wc;

   // Each entry: packet length in bytes [11:4], idle cycles between beats [3:0]
   localparam logic [11:0] VEC [6] = '{
      {8'd10, 4'd0}, {8'd7, 4'd2}, {8'd1, 4'd0},
      {8'd40, 4'd1}, {8'd4, 4'd0}, {8'd2, 4'd0}
   };

   always #5 clk = ~clk;

   rxbuf_space_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .eob_words(eob_words),
      .buf_load_valid(buf_load_valid), .buf_load_addr(buf_load_addr),
      .buf_load_wc(buf_load_wc), .fetch_req(fetch_req), .fetch_empty(fetch_empty),
      .rsrc_exhausted(rsrc_exhausted), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
      .pkt_eop(pkt_eop), .pkt_last_bytes(pkt_last_bytes), .wr_en(wr_en),
      .wr_addr(wr_addr), .rem_words(rem_words), .done_valid(done_valid),
      .done_addr(done_addr), .done_bytes(done_bytes), .done_last(done_last),
      .pkt_drop(pkt_drop)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_buf(input longint addr, input longint wc);
      @(negedge clk);
      buf_load_valid = 1'b1;
      buf_load_addr  = ADDR_W'(addr);
      buf_load_wc    = WC_W'(wc);
      @(negedge clk);
      buf_load_valid = 1'b0;
      exp_ptr = addr & ~longint'(1);
      exp_wc  = wc;
      chk("R9 rem_words after load", rem_words, wc);
      chk("R9 exhausted cleared", rsrc_exhausted, 0);
   endtask

   task automatic send_pkt(input int len, input int gap, input bit acc);
      int     nb;
      longint start;
      bit     last;
      nb    = (len + 1) / 2;
      start = exp_ptr;
      for (int i = 0; i < nb; i++) begin
         @(negedge clk);
         pkt_valid      = 1'b1;
         pkt_sop        = (i == 0);
         pkt_eop        = (i == nb - 1);
         pkt_last_bytes = pkt_eop ? 2'(len - 2 * i) : 2'd0;
         #4;
         chk(acc ? "R3 wr_en on beat" : "R2 no write when dropped", wr_en, acc);
         if (acc) chk("R3 R4 beat address", wr_addr, start + 2 * i);
         if (i != nb - 1) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               pkt_valid = 1'b0;
               #4;
               chk("R3 idle no write", wr_en, 0);
            end
         end
      end
      @(negedge clk);
      pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0;
      if (acc) begin
         exp_ptr = start + 2 * nb;
         exp_wc  = (exp_wc > nb) ? exp_wc - nb : 0;
         last    = (exp_wc < EOB);
         chk("R5 done_valid", done_valid, 1);
         chk("R5 done_addr", done_addr, start);
         chk("R5 done_bytes", done_bytes, len);
         chk("R7 done_last", done_last, last);
         chk("R6 rem_words", rem_words, exp_wc);
         chk("R2 no drop on accept", pkt_drop, 0);
      end else begin
         chk("R2 no done on drop", done_valid, 0);
         chk("R2 drop pulse", pkt_drop, 1);
      end
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rx_enable = 1'b0; eob_words = WC_W'(EOB);
      buf_load_valid = 1'b0; buf_load_addr = '0; buf_load_wc = '0;
      fetch_empty = 1'b0; pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0;
      pkt_last_bytes = '0;
      exp_ptr = 0; exp_wc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 wr_en", wr_en, 0);
      chk("R10 done_valid", done_valid, 0);
      chk("R10 pkt_drop", pkt_drop, 0);
      chk("R10 exhausted", rsrc_exhausted, 0);
      chk("R10 rem_words", rem_words, 0);
      chk("R10 fetch_req", fetch_req, 0);

      // unaligned load, then enable
      load_buf(64'h1001, 40);
      chk("R1 aligned start", exp_ptr, 64'h1000);
      rx_enable = 1'b1;
      @(negedge clk);
      chk("R9 fetch_req low with buffer", fetch_req, 0);

      foreach (VEC[k]) send_pkt(int'(VEC[k][11:4]), int'(VEC[k][3:0]), 1'b1);

      // threshold crossed on the last table packet
      chk("R7 fetch_req after release", fetch_req, 1);

      // R8 exhaustion
      @(negedge clk);
      fetch_empty = 1'b1;
      @(negedge clk);
      chk("R8 exhausted set", rsrc_exhausted, 1);
      send_pkt(4, 0, 1'b0);
      chk("R8 exhausted held", rsrc_exhausted, 1);
      fetch_empty = 1'b0;

      load_buf(64'h2003, 10);
      chk("R9 fetch_req dropped", fetch_req, 0);
      send_pkt(3, 0, 1'b1);
      chk("R1 R4 second buffer start", done_addr, 64'h2002);

      // R2 disabled receiver
      rx_enable = 1'b0;
      send_pkt(2, 0, 1'b0);
      chk("R2 rem unchanged while disabled", rem_words, exp_wc);
      rx_enable = 1'b1;

      // R6 oversize packet saturates
      send_pkt(30, 0, 1'b1);
      chk("R6 saturated at zero", rem_words, 0);
      chk("R7 fetch_req after saturation", fetch_req, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule